// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight synchronous interrupt lines into a register of pending requests. Each line can be set to edge sensing or level sensing through a trigger-mode register. In edge mode a request is caught on a low-to-high transition and stays pending until it is acknowledged. In level mode the request simply follows the line. The block keeps a registered copy of each line's previous level so that it can detect rising edges.

An acknowledge strobe with a line index retires an edge-mode request. It leaves level-mode requests alone, because those clear only when the source drops its line. Some lines must never be level sensed, so the trigger-mode register accepts writes only on the bits set in a per-instance writable mask. For every line the block also reports two things each cycle: whether an active line is blocked by the mask register supplied to it, and whether a new unmasked request was just latched. Priority resolution and any bus decoding belong to the surrounding controller.

Top module: `irq_req_latch`

## Requirements
- R1: A line in level mode (trigger bit = 1) has its request bit equal to the line level sampled at the previous clock edge. The bit is set while the line is high and cleared one cycle after the line goes low.
- R2: A line in edge mode (trigger bit = 0) sets its request bit when the line is high and its last-level bit is low. A low line or a held-high line does not clear a pending edge request.
- R3: On every clock edge out of reset, each last-level bit takes the current line level, in both modes.
- R4: An acknowledge (ack_valid = 1, ack_idx = n) clears request bit n when line n is in edge mode. If a rising edge on line n arrives in the same cycle, the set wins and the bit stays 1.
- R5: An acknowledge aimed at a level-mode line has no effect: its request bit keeps following the line.
- R6: A trigger-mode write stores trig_wdata AND WR_MASK. With the default mask 8'hF8, bits 0 to 2 always read 0 and stay edge sensed. Without a write, the register holds its value.
- R7: new_req_o[n] pulses for one cycle after an evaluation in which line n had a set condition, request bit n was clear, and mask bit n was 0. It is registered and always implies req_o[n].
- R8: masked_o[n] is 1 one cycle after an evaluation in which line n was high and mask bit n was 1. Masking does not stop the request bit from being latched.
- R9: While rst is high, the request, last-level, trigger-mode, masked and new-request outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NUM_LINES | Interrupt lines, synchronous to clk |
| imr_i | input | NUM_LINES | Mask register value, 1 = line masked |
| trig_we | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | NUM_LINES | Trigger-mode write data, 1 = level mode |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | $clog2(NUM_LINES) | Index of the acknowledged line |
| req_o | output | NUM_LINES | Pending request vector |
| last_o | output | NUM_LINES | Registered previous line levels |
| trig_o | output | NUM_LINES | Current trigger-mode register |
| masked_o | output | NUM_LINES | Active line blocked by mask, per line |
| new_req_o | output | NUM_LINES | One-cycle pulse for a newly latched unmasked request |

## Verification
Edge-mode lines are driven with single pulses, held-high levels and repeated pulses. This shows that only a rising edge sets a request and that a falling line does not clear it. Acknowledges are applied alone and together with a fresh rising edge, which shows the clear and the set-wins ordering. After a write of all ones, level-mode lines are toggled and acknowledged; this shows that they follow the line and ignore the acknowledge, while the mask-protected low bits stay in edge mode. Mask patterns are applied to high lines to separate the masked report from the new-request pulse.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_trig_mode_reg.sv
module irq_trig_mode_reg #(
  parameter int          NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] trig_q
);
  always_ff @(posedge clk) begin
    if (rst)     trig_q <= '0;
    else if (we) trig_q <= wdata & WR_MASK;
  end

  AST_TRIG_WRITE: assert property (@(posedge clk) disable iff (rst) we |=> trig_q == ($past(wdata) & WR_MASK)); // R6
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (rst) !we |=> $stable(trig_q)); // R6
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line,
  input  trig_mode_e mode,
  input  logic       imr,
  input  logic       ack_hit,
  output logic       req_q,
  output logic       last_q,
  output logic       masked_q,
  output logic       new_q
);
  logic set_ev;
  logic req_nxt;

  always_comb begin
    if (mode == TRIG_LEVEL) begin
      set_ev  = line;
      req_nxt = line;
    end else begin
      set_ev  = line && !last_q;
      if (set_ev)       req_nxt = 1'b1;
      else if (ack_hit) req_nxt = 1'b0;
      else              req_nxt = req_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      last_q   <= 1'b0;
      masked_q <= 1'b0;
      new_q    <= 1'b0;
    end else begin
      req_q    <= req_nxt;
      last_q   <= line;
      masked_q <= line && imr;
      new_q    <= set_ev && !req_q && !imr;
    end
  end

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst) (mode == TRIG_LEVEL) |=> req_q == $past(line)); // R1
  AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (rst) (mode == TRIG_EDGE && req_q && !ack_hit) |=> req_q); // R2
  AST_LAST_TRACK: assert property (@(posedge clk) disable iff (rst) !rst |=> last_q == $past(line)); // R3
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst) (mode == TRIG_EDGE && ack_hit && !(line && !last_q)) |=> !req_q); // R4
  AST_ACK_LEVEL_IGNORED: assert property (@(posedge clk) disable iff (rst) (mode == TRIG_LEVEL && ack_hit && line) |=> req_q); // R5
  AST_NEW_IMPLIES_REQ: assert property (@(posedge clk) disable iff (rst) new_q |-> req_q); // R7
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int                   NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK   = 8'hF8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_LINES-1:0]         line_i,
  input  logic [NUM_LINES-1:0]         imr_i,
  input  logic                         trig_we,
  input  logic [NUM_LINES-1:0]         trig_wdata,
  input  logic                         ack_valid,
  input  logic [$clog2(NUM_LINES)-1:0] ack_idx,
  output logic [NUM_LINES-1:0]         req_o,
  output logic [NUM_LINES-1:0]         last_o,
  output logic [NUM_LINES-1:0]         trig_o,
  output logic [NUM_LINES-1:0]         masked_o,
  output logic [NUM_LINES-1:0]         new_req_o
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] ack_hit;

  irq_trig_mode_reg #(
    .NUM_LINES (NUM_LINES),
    .WR_MASK   (WR_MASK)
  ) u_trig (
    .clk    (clk),
    .rst    (rst),
    .we     (trig_we),
    .wdata  (trig_wdata),
    .trig_q (trig_o)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign ack_hit[g] = ack_valid && (ack_idx == IDX_W'(g));

    irq_line_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .line     (line_i[g]),
      .mode     (trig_mode_e'(trig_o[g])),
      .imr      (imr_i[g]),
      .ack_hit  (ack_hit[g]),
      .req_q    (req_o[g]),
      .last_q   (last_o[g]),
      .masked_q (masked_o[g]),
      .new_q    (new_req_o[g])
    );
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ack_hit)); // R4
  AST_NEW_UNMASKED: assert property (@(posedge clk) disable iff (rst) (new_req_o & masked_o) == '0); // R8
endmodule

// File: tb/test_irq_req_latch.sv
`timescale 1ns/1ps
module test_irq_req_latch;
  localparam int N = 8;
  localparam logic [N-1:0] MASK = 8'hF8;

  typedef struct {
    string        tag;
    logic [N-1:0] req, last, trig, masked, newr;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] line_i = '0, imr_i = '0, trig_wdata = '0;
  logic trig_we = 1'b0, ack_valid = 1'b0;
  logic [2:0] ack_idx = '0;
  logic [N-1:0] req_o, last_o, trig_o, masked_o, new_req_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  logic [N-1:0] m_req = '0, m_last = '0, m_trig = '0, m_masked = '0, m_new = '0;

  always #10 clk = ~clk;

  irq_req_latch #(.NUM_LINES(N), .WR_MASK(MASK)) i_irq_req_latch (
    .clk(clk), .rst(rst), .line_i(line_i), .imr_i(imr_i),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .ack_valid(ack_valid), .ack_idx(ack_idx),
    .req_o(req_o), .last_o(last_o), .trig_o(trig_o),
    .masked_o(masked_o), .new_req_o(new_req_o)
  );

  task automatic step(input string tag, input logic r, input logic [N-1:0] ln,
                      input logic [N-1:0] mk, input logic we, input logic [N-1:0] wd,
                      input logic av, input logic [2:0] ai);
    exp_t e;
    logic [N-1:0] nreq, nnew;
    @(negedge clk);
    rst = r; line_i = ln; imr_i = mk; trig_we = we; trig_wdata = wd;
    ack_valid = av; ack_idx = ai;
    if (r) begin
      m_req = '0; m_last = '0; m_trig = '0; m_masked = '0; m_new = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic s;
        s = m_trig[i] ? ln[i] : (ln[i] && !m_last[i]);
        if (m_trig[i])              nreq[i] = ln[i];
        else if (s)                 nreq[i] = 1'b1;
        else if (av && ai == 3'(i)) nreq[i] = 1'b0;
        else                        nreq[i] = m_req[i];
        nnew[i] = s && !m_req[i] && !mk[i];
      end
      m_new = nnew; m_masked = ln & mk; m_req = nreq; m_last = ln;
      if (we) m_trig = wd & MASK;
    end
    e.tag = tag; e.req = m_req; e.last = m_last; e.trig = m_trig;
    e.masked = m_masked; e.newr = m_new;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (req_o !== e.req || last_o !== e.last || trig_o !== e.trig ||
            masked_o !== e.masked || new_req_o !== e.newr) begin
          bad++;
          $display("FAIL %s: req/last/trig/masked/new actual=%h/%h/%h/%h/%h expected=%h/%h/%h/%h/%h",
                   e.tag, req_o, last_o, trig_o, masked_o, new_req_o,
                   e.req, e.last, e.trig, e.masked, e.newr);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    // R9: reset holds everything at zero even with lines high and a write
    step("R9", 1, 8'hFF, 8'h00, 1, 8'hFF, 1, 3'd0);
    step("R9", 1, 8'hFF, 8'hFF, 0, 8'h00, 0, 3'd0);
    step("R3", 0, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0);
    // R2/R7: edge pulses on lines 0 and 5
    step("R2", 0, 8'h21, 8'h00, 0, 8'h00, 0, 3'd0);
    step("R2", 0, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0);
    step("R7", 0, 8'h01, 8'h00, 0, 8'h00, 0, 3'd0);
    step("R2", 0, 8'h01, 8'h00, 0, 8'h00, 0, 3'd0);
    // R4: acknowledge clears edge request while line is held high
    step("R4", 0, 8'h01, 8'h00, 0, 8'h00, 1, 3'd0);
    step("R3", 0, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0);
    // R4: rising edge and acknowledge in the same cycle, set wins
    step("R4", 0, 8'h01, 8'h00, 0, 8'h00, 1, 3'd0);
    step("R4", 0, 8'h00, 8'h00, 0, 8'h00, 1, 3'd5);
    // R6: writing all ones leaves the low three bits in edge mode
    step("R6", 0, 8'h00, 8'h00, 1, 8'hFF, 0, 3'd0);
    step("R6", 0, 8'h00, 8'h00, 0, 8'h55, 0, 3'd0);
    // R1: level lines 3 and 4 follow the input
    step("R1", 0, 8'h18, 8'h00, 0, 8'h00, 0, 3'd0);
    step("R1", 0, 8'h18, 8'h00, 0, 8'h00, 0, 3'd0);
    step("R1", 0, 8'h10, 8'h00, 0, 8'h00, 0, 3'd0);
    step("R1", 0, 8'h00, 8'h00, 0, 8'h00, 0, 3'd0);
    // R5: acknowledge on a high level line has no effect
    step("R5", 0, 8'h08, 8'h00, 0, 8'h00, 1, 3'd3);
    step("R5", 0, 8'h08, 8'h00, 1, 8'h00, 1, 3'd3);
    // R8: masked lines report masked and no new pulse, but still latch
    step("R8", 0, 8'h0A, 8'h0A, 0, 8'h00, 0, 3'd0);
    step("R8", 0, 8'h00, 8'hFF, 0, 8'h00, 0, 3'd0);
    step("R6", 0, 8'h06, 8'h00, 1, 8'h07, 0, 3'd0);
    step("R2", 0, 8'h04, 8'h00, 0, 8'h00, 1, 3'd1);
    step("R3", 0, 8'hF0, 8'h00, 0, 8'h00, 0, 3'd0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule